// File: doc/BRIEF.md
# DRAM Compressed Parallel-Test Core

This block models the device side of a byte-wide dynamic memory whose storage is split into two equal halves that share one internal address. It watches the strobe inputs (row strobe, column strobe, write enable) sampled on a system clock, recognises the cycle kind at each row-strobe falling edge, and keeps a test-mode flag. In normal operation the most significant row address bit picks one half, so the pair of halves behaves as one flat byte array.

When a write-enable-and-column-before-row cycle arrives with a fixed key on the row address, the core switches into a compressed test mode. A write in that mode places the same byte in both halves at the shared location, so a pattern fills the array in half the cycles. A read returns, bit by bit, a pass flag that is 1 where the two halves agree and 0 where they differ. Any refresh-style cycle (column-before-row with write enable high, a row-only cycle, or a hidden refresh) brings the core back to normal mode.

Top module: `dram_cmp_test`

## Requirements
- R1: After reset, `test_mode`, `dout_en` and `dout` are all 0 and every stored byte in both halves is 0.
- R2: In normal mode, address bit ROW_W-1 of the latched row selects the half (0 = lower, 1 = upper); the location within the half is the remaining row bits followed by the column bits, and a read returns the stored byte unchanged.
- R3: A row-strobe falling edge sampled with column strobe low and write enable low, while not in test mode, with address bits ROW_W-2 down to 0 all 1, sets `test_mode` one clock later; address bit ROW_W-1 does not matter.
- R4: The same cycle with any of address bits ROW_W-2 down to 0 at 0 leaves `test_mode` at 0 and leaves stored data unchanged.
- R5: In test mode, a write stores `din` at the addressed location in both halves at once, regardless of address bit ROW_W-1.
- R6: In test mode, a read returns for each bit position 1 when the two halves hold equal bits there and 0 when they differ.
- R7: A row-strobe falling edge with column strobe low and write enable high clears `test_mode` one clock later.
- R8: A row cycle in which the column strobe never falls before the row strobe rises clears `test_mode`.
- R9: A hidden refresh (column strobe held low after a read while the row strobe rises and falls again, write enable high) clears `test_mode` and keeps the read data on `dout`.
- R10: In test mode, a further write-enable-and-column-before-row cycle leaves `test_mode` at 1 whatever the address.
- R11: `dout_en` rises one clock after a sampled column-strobe falling edge of a read and falls one clock after the column strobe is sampled high again; a write never raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ROW_W | Multiplexed row / column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or per-bit compare result |
| dout_en | output | 1 | Read data valid / output driven |
| test_mode | output | 1 | Compressed test mode active |

## Verification
The checker watches mode transitions on every clock: entry only after a keyed write-enable-and-column-before-row edge, no entry with a bad key, staying in the mode on a repeated entry cycle, leaving it on a column-before-row refresh, and the rise and fall of `dout_en` against the column strobe. Data paths cannot be seen by properties at the ports, so mirroring into both halves, the per-bit compare result, half selection in normal mode, and the exit paths through row-only and hidden refresh are shown only by the bench, which tracks both halves in its own model across random and directed sequences.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    // Classification of a sampled row-strobe falling edge.
    typedef enum logic [2:0] {
        RF_NONE  = 3'd0,
        RF_ROW   = 3'd1,   // normal row activation
        RF_ENTER = 3'd2,   // keyed entry into compressed test mode
        RF_KEEP  = 3'd3,   // refresh, mode unchanged
        RF_EXIT  = 3'd4    // refresh that leaves test mode
    } ras_evt_e;

endpackage

// File: rtl/tmc_half_array.sv
module tmc_half_array #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/tmc_read_merge.sv
module tmc_read_merge #(
    parameter int DATA_W = 8
) (
    input  logic              tm,
    input  logic              half_sel,
    input  logic [DATA_W-1:0] lo_data,
    input  logic [DATA_W-1:0] hi_data,
    output logic [DATA_W-1:0] merged
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        // compressed: agreement flag; normal: selected half
        assign merged[b] = tm ? ~(lo_data[b] ^ hi_data[b])
                              : (half_sel ? hi_data[b] : lo_data[b]);
    end
endmodule

// File: rtl/tmc_cycle_ctl.sv
module tmc_cycle_ctl
    import tmc_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8,
    localparam int IDX_W = ROW_W - 1 + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic [DATA_W-1:0] rd_merged,
    output logic [1:0]        wr_en,
    output logic [IDX_W-1:0]  arr_idx,
    output logic              half_sel,
    output logic              tm,
    output logic              oe,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              ras;
        logic              cas;
        logic              row_cyc;
        logic              cas_seen;
        logic              tm;
        logic              oe;
        logic [ROW_W-1:0]  row;
        logic [DATA_W-1:0] dout;
    } ctl_state_t;

    ctl_state_t st_q, st_d;
    ras_evt_e   ras_evt;
    logic       key_ok;
    logic       ras_rise;
    logic       col_hit;

    assign key_ok   = &addr[ROW_W-2:0];
    assign ras_rise = !st_q.ras && ras_n;
    assign col_hit  = st_q.cas && !cas_n && st_q.row_cyc && !ras_n;

    always_comb begin
        ras_evt = RF_NONE;
        if (st_q.ras && !ras_n) begin
            if (cas_n) begin
                ras_evt = RF_ROW;
            end else if (!we_n) begin
                ras_evt = (!st_q.tm && key_ok) ? RF_ENTER : RF_KEEP;
            end else begin
                ras_evt = RF_EXIT;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.ras = ras_n;
        st_d.cas = cas_n;

        case (ras_evt)
            RF_ROW: begin
                st_d.row_cyc  = 1'b1;
                st_d.cas_seen = 1'b0;
                st_d.row      = addr;
            end
            RF_ENTER: begin
                st_d.tm      = 1'b1;
                st_d.row_cyc = 1'b0;
            end
            RF_KEEP: begin
                st_d.row_cyc = 1'b0;
            end
            RF_EXIT: begin
                st_d.tm      = 1'b0;
                st_d.row_cyc = 1'b0;
            end
            default: ;
        endcase

        if (ras_rise) begin
            if (st_q.row_cyc && !st_q.cas_seen) begin
                st_d.tm = 1'b0;   // row-only refresh
            end
            st_d.row_cyc = 1'b0;
        end

        if (col_hit) begin
            st_d.cas_seen = 1'b1;
            if (we_n) begin
                st_d.dout = rd_merged;
                st_d.oe   = 1'b1;
            end
        end

        if (!st_q.cas && cas_n) begin
            st_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ras: 1'b1, cas: 1'b1, row_cyc: 1'b0, cas_seen: 1'b0,
                      tm: 1'b0, oe: 1'b0, row: '0, dout: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_idx  = {st_q.row[ROW_W-2:0], addr[COL_W-1:0]};
    assign half_sel = st_q.row[ROW_W-1];
    assign wr_en[0] = col_hit && !we_n && (st_q.tm || !half_sel);
    assign wr_en[1] = col_hit && !we_n && (st_q.tm ||  half_sel);
    assign tm       = st_q.tm;
    assign oe       = st_q.oe;
    assign rd_data  = st_q.dout;
endmodule

// File: rtl/dram_cmp_test.sv
module dram_cmp_test #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              test_mode
);
    localparam int IDX_W = ROW_W - 1 + COL_W;

    logic [1:0]        wr_en;
    logic [IDX_W-1:0]  arr_idx;
    logic              half_sel;
    logic              tm;
    logic [DATA_W-1:0] half_rd [2];
    logic [DATA_W-1:0] rd_merged;

    tmc_cycle_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .rd_merged (rd_merged),
        .wr_en     (wr_en),
        .arr_idx   (arr_idx),
        .half_sel  (half_sel),
        .tm        (tm),
        .oe        (dout_en),
        .rd_data   (dout)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        tmc_half_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arr (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en[h]),
            .idx   (arr_idx),
            .wdata (din),
            .rdata (half_rd[h])
        );
    end

    tmc_read_merge #(.DATA_W(DATA_W)) u_merge (
        .tm       (tm),
        .half_sel (half_sel),
        .lo_data  (half_rd[0]),
        .hi_data  (half_rd[1]),
        .merged   (rd_merged)
    );

    assign test_mode = tm;
endmodule

// File: rtl/tmc_dram_chk.sv
module tmc_dram_chk #(
    parameter int ROW_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [ROW_W-1:0] addr,
    input logic             dout_en,
    input logic             test_mode
);
    assert_keyed_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && $fell(ras_n) && !cas_n && !we_n && (&addr[ROW_W-2:0]))
        |=> test_mode);

    assert_entry_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> ($past($fell(ras_n)) && !$past(cas_n) && !$past(we_n)));

    assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && $fell(ras_n) && !cas_n && !(&addr[ROW_W-2:0]))
        |=> !test_mode);

    assert_cbr_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && $fell(ras_n) && !cas_n && we_n) |=> !test_mode);

    assert_wcbr_stay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && $fell(ras_n) && !cas_n && !we_n) |=> test_mode);

    assert_oe_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> ($past(cas_n, 2) && !$past(cas_n) && $past(we_n)));

    assert_oe_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && cas_n) |=> !dout_en);
endmodule

bind dram_cmp_test tmc_dram_chk #(.ROW_W(ROW_W)) i_chk (.*);

// File: tb/test_dram_cmp_test.sv
module test_dram_cmp_test;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 3;
    localparam int CW = 2;
    localparam int DW = 8;
    localparam int IW = RW - 1 + CW;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic [RW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic          test_mode;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [DW-1:0] m_lo [DEPTH];
    logic [DW-1:0] m_hi [DEPTH];
    logic          m_tm = 1'b0;

    dram_cmp_test #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW)) i_dram_cmp_test (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .test_mode(test_mode)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] idx_of(input logic [RW-1:0] row, input logic [CW-1:0] col);
        return {row[RW-2:0], col};
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [RW-1:0] row, input logic [CW-1:0] col);
        logic [IW-1:0] i;
        i = idx_of(row, col);
        if (m_tm) return ~(m_lo[i] ^ m_hi[i]);
        return row[RW-1] ? m_hi[i] : m_lo[i];
    endfunction

    // One row cycle with a single column access; optional hidden refresh after a read.
    task automatic access(input logic [RW-1:0] row, input logic [CW-1:0] col,
                          input logic wr, input logic [DW-1:0] data, input logic hidden,
                          output logic [DW-1:0] rd, output logic en);
        @(negedge clk); ras_n = 1'b0; addr = row; cas_n = 1'b1; we_n = 1'b1;
        @(negedge clk); addr = RW'(col); we_n = !wr; din = data; cas_n = 1'b0;
        @(negedge clk); rd = dout; en = dout_en; we_n = 1'b1;
        if (hidden) begin
            ras_n = 1'b1;
            @(negedge clk); ras_n = 1'b0;
            @(negedge clk); ras_n = 1'b1;
            @(negedge clk); chk("R9 data held", dout, rd);
            cas_n = 1'b1;
        end else begin
            cas_n = 1'b1;
            @(negedge clk); ras_n = 1'b1;
        end
        @(negedge clk);
        chk("R11 oe drop", dout_en, 1'b0);
    endtask

    task automatic do_write(input logic [RW-1:0] row, input logic [CW-1:0] col,
                            input logic [DW-1:0] data, input string req);
        logic [DW-1:0] rd;
        logic en;
        logic [IW-1:0] i;
        access(row, col, 1'b1, data, 1'b0, rd, en);
        chk({req, " R11 no oe on write"}, en, 1'b0);
        i = idx_of(row, col);
        if (m_tm) begin
            m_lo[i] = data; m_hi[i] = data;
        end else if (row[RW-1]) m_hi[i] = data;
        else m_lo[i] = data;
    endtask

    task automatic do_read(input logic [RW-1:0] row, input logic [CW-1:0] col,
                           input logic hidden, input string req);
        logic [DW-1:0] rd;
        logic [DW-1:0] exp;
        logic en;
        exp = exp_read(row, col);
        access(row, col, 1'b0, '0, hidden, rd, en);
        chk(req, rd, exp);
        chk("R11 oe on read", en, 1'b1);
        if (hidden) begin
            m_tm = 1'b0;
            chk("R9 hidden exit", test_mode, m_tm);
        end
    endtask

    // Column-before-row cycle; we selects entry-type (0) or plain refresh (1).
    task automatic cbr(input logic we, input logic [RW-1:0] a, input string req);
        @(negedge clk); cas_n = 1'b0; we_n = we;
        @(negedge clk); ras_n = 1'b0; addr = a;
        @(negedge clk); ras_n = 1'b1;
        @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        if (!we) begin
            if (!m_tm && (&a[RW-2:0])) m_tm = 1'b1;
        end else m_tm = 1'b0;
        chk(req, test_mode, m_tm);
    endtask

    task automatic ror(input logic [RW-1:0] row, input string req);
        @(negedge clk); ras_n = 1'b0; addr = row;
        @(negedge clk);
        @(negedge clk); ras_n = 1'b1;
        @(negedge clk);
        m_tm = 1'b0;
        chk(req, test_mode, m_tm);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_lo[i] = '0; m_hi[i] = '0;
        end
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1 test_mode", test_mode, 1'b0);
        chk("R1 dout_en", dout_en, 1'b0);
        chk("R1 dout", dout, '0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(3'b101, 2'd2, 1'b0, "R1 array cleared");

        // R2: same location, both halves, distinct data
        do_write(3'b001, 2'd1, 8'hA5, "R2");
        do_write(3'b101, 2'd1, 8'h0F, "R2");
        do_read(3'b001, 2'd1, 1'b0, "R2 lower half");
        do_read(3'b101, 2'd1, 1'b0, "R2 upper half");

        // R4: bad key does not enter
        cbr(1'b0, 3'b110, "R4 bad key");
        cbr(1'b0, 3'b101, "R4 bad key");
        do_read(3'b001, 2'd1, 1'b0, "R4 data kept");

        // R3 + R6: enter with top bit 0, compare differing halves
        cbr(1'b0, 3'b011, "R3 entry");
        do_read(3'b001, 2'd1, 1'b0, "R6 mismatch flags");
        chk("R6 value", exp_read(3'b001, 2'd1), 8'h55);
        // R10: repeated entry cycle stays in mode
        cbr(1'b0, 3'b000, "R10 stay");
        // R5: test write then check both halves in normal mode
        do_write(3'b100, 2'd3, 8'h3C, "R5");
        do_read(3'b000, 2'd3, 1'b0, "R6 all match");
        // R7 exit
        cbr(1'b1, 3'b000, "R7 cbr exit");
        do_read(3'b000, 2'd3, 1'b0, "R5 lower copy");
        do_read(3'b100, 2'd3, 1'b0, "R5 upper copy");

        // R3 with top bit 1, then R8 row-only exit
        cbr(1'b0, 3'b111, "R3 entry top bit ignored");
        ror(3'b010, "R8 row-only exit");
        // R9 hidden refresh exit
        cbr(1'b0, 3'b011, "R3 entry");
        do_read(3'b101, 2'd1, 1'b1, "R6 before hidden");

        // Random mixture
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [RW-1:0] r;
            logic [CW-1:0] c;
            op = $urandom_range(0, 6);
            r = RW'($urandom);
            c = CW'($urandom);
            case (op)
                0, 1: do_write(r, c, DW'($urandom), m_tm ? "R5 rnd" : "R2 rnd");
                2, 3: do_read(r, c, 1'b0, m_tm ? "R6 rnd" : "R2 rnd");
                4: cbr(1'b0, RW'($urandom_range(0, 1) ? 32'hFF : $urandom),
                       m_tm ? "R10 rnd" : "R3/R4 rnd");
                5: begin
                    case ($urandom_range(0, 2))
                        0: cbr(1'b1, r, "R7 rnd");
                        1: ror(r, "R8 rnd");
                        default: do_read(r, c, 1'b1, "R9 rnd read");
                    endcase
                end
                default: chk("R3/R7 mode track", test_mode, m_tm);
            endcase
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule